// File: doc/BRIEF.md
# Programmable SYSREF Pulse Generator

This block produces the SYSREF alignment strobe for a 64b/66b converter link, running entirely in the link clock domain and steered by one 32-bit control word. The internal generator has three behaviours. In single-pulse mode, software sets and then clears a level bit. In continuous mode, the output is a square wave. In gapped mode, the high time within each period is programmable. The period is always a whole number of 16-cycle multiblocks scaled by the extended-multiblock count E, which is a build parameter. A source-select bit can route an external SYSREF input to the output instead, and a phase bit moves the launch of the internal strobe to the falling clock edge.

Settings that cannot be honoured are repaired rather than rejected. A multiplier whose product with E leaves the range 1 to 16 acts as 1. A gapped high time of zero, or one that does not fit inside the period, falls back to half the period. The status word reports the period and high time actually in use. Mode, multiplier and high time are captured only while the generator reset input is high. A running waveform therefore never changes part-way through a period. A sticky status flag records any rising edge of the selected strobe, and software clears it with a write.

Top module: `sysref_pulse_gen`

## Requirements
- R1: After rst_n is released, sysref_out is 0, the edge flag status_word[16] is 0, and status_word[15:0] reports a period of 16·E and a high time of 8·E.
- R2: With ctrl_word[1:0]=01 (continuous), the multiplier in ctrl_word[6:2] and ctrl_word[7]=1, rising edges of sysref_out are E·mult·16 cycles apart. status_word[7:0] gives that period modulo 256, so 0x00 stands for 256.
- R3: A multiplier of 0, or one with E·mult greater than 16, behaves exactly as a multiplier of 1.
- R4: In continuous mode the output is high for exactly half the period in each period.
- R5: With ctrl_word[1:0]=10 (gapped), the output is high for ctrl_word[15:8] cycles per period when that value lies in 1 to period−1, and for half the period otherwise. status_word[15:8] reports the high time in use.
- R6: Mode, multiplier and high time are taken from ctrl_word only while gen_rst is 1. Changing them while gen_rst is 0 alters neither the waveform nor status_word[15:0].
- R7: While gen_rst is 1, the internal strobe is held low. With the rising-edge phase selected, sysref_out rises at the first clock edge that samples gen_rst low.
- R8: ctrl_word[16]=0 launches the internal strobe on the rising clock edge. ctrl_word[16]=1 launches it on the falling clock edge.
- R9: With ctrl_word[1:0]=00 (single pulse), sysref_out follows ctrl_word[17] with one clock of latency.
- R10: With ctrl_word[7]=0, sysref_out equals ext_sysref_in delayed by one rising edge. The mode and phase fields have no effect in this case.
- R11: A rising edge of the selected strobe sets status_word[16]. A cycle with stat_wr_en=1 and stat_wr_data[16]=1 clears it, and the clear wins when both happen in the same cycle.
- R12: The reserved mode ctrl_word[1:0]=11 keeps the internal strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| gen_rst | input | 1 | Generator reset; timing fields are captured while high |
| ctrl_word | input | 32 | Control word (mode, multiplier, source, high time, phase, manual level) |
| ext_sysref_in | input | 1 | External SYSREF to pass through |
| stat_wr_en | input | 1 | Status write strobe |
| stat_wr_data | input | 32 | Status write data; bit 16 set clears the edge flag |
| sysref_out | output | 1 | SYSREF strobe |
| status_word | output | 32 | [7:0] period in use (0 = 256), [15:8] high time in use, [16] edge flag |

## Verification
The bench targets the period boundaries. A 256-cycle period must report 0x00. A generator that kept an eight-bit counter would wrap to a zero-length period or show a 0x00 high time. The bench also tries high times of 0, period−1 and period. A clamp that used the wrong comparison would either produce a solid-high output or keep the illegal value. Rewriting the control word during a running waveform exposes any design that samples its settings continuously, because the period would change mid-run. The bench also lands a clear write on the same edge as a strobe rising edge, which exposes a wrong set/clear priority, and it checks the launch edge by observing the clock level at the instant the output rises.

// File: rtl/sysref_pkg.sv
package sysref_pkg;
  localparam int CTRL_W   = 32;
  localparam int DUTY_W   = 8;
  localparam int PER_W    = 9;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_CONT   = 2'b01,
    MODE_GAP    = 2'b10,
    MODE_RSVD   = 2'b11
  } sr_mode_e;

  typedef struct packed {
    sr_mode_e            mode;
    logic [PER_W-1:0]    period;
    logic [DUTY_W-1:0]   duty;
  } sr_cfg_t;

  // control word field positions
  localparam int MODE_LSB  = 0;
  localparam int MULT_LSB  = 2;
  localparam int MULT_W    = 5;
  localparam int SRC_BIT   = 7;
  localparam int DUTY_LSB  = 8;
  localparam int PHASE_BIT = 16;
  localparam int LEVEL_BIT = 17;
  localparam int FLAG_BIT  = 16;
endpackage

// File: rtl/sysref_cfg_clamp.sv
module sysref_cfg_clamp
  import sysref_pkg::*;
#(
  parameter int EMB_E     = 1,
  parameter int MB_CYCLES = 16,
  parameter int MAX_PROD  = 16
) (
  input  logic [CTRL_W-1:0] ctrl,
  output sr_cfg_t           cfg
);
  localparam int PROD_W = MULT_W + $clog2(MAX_PROD + 1);

  logic [MULT_W-1:0] mult;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] prod_eff;
  logic              mult_ok;
  logic [PER_W-1:0]  per;
  logic [DUTY_W-1:0] req;
  logic [DUTY_W-1:0] half;
  sr_mode_e          mode;

  always_comb begin
    mode     = sr_mode_e'(ctrl[MODE_LSB +: 2]);
    mult     = ctrl[MULT_LSB +: MULT_W];
    prod     = PROD_W'(EMB_E) * PROD_W'(mult);
    mult_ok  = (mult != '0) && (prod <= PROD_W'(MAX_PROD));
    prod_eff = mult_ok ? prod : PROD_W'(EMB_E);
    per      = PER_W'(prod_eff * PROD_W'(MB_CYCLES));
    half     = DUTY_W'(per >> 1);
    req      = ctrl[DUTY_LSB +: DUTY_W];
    cfg.mode   = mode;
    cfg.period = per;
    if (mode == MODE_GAP && req != '0 && PER_W'(req) < per)
      cfg.duty = req;
    else
      cfg.duty = half;
  end
endmodule

// File: rtl/sysref_cycle_counter.sv
module sysref_cycle_counter
  import sysref_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    hold,
  input  sr_cfg_t cfg,
  input  logic    manual_lvl,
  output logic    lvl
);
  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] last;
  logic             next_lvl;

  assign last = cfg.period - PER_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n || hold)
      cnt <= '0;
    else if (cnt == last)
      cnt <= '0;
    else
      cnt <= cnt + PER_W'(1);
  end

  always_comb begin
    unique case (cfg.mode)
      MODE_CONT, MODE_GAP: next_lvl = (cnt < PER_W'(cfg.duty));
      MODE_SINGLE:         next_lvl = manual_lvl;
      default:             next_lvl = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || hold)
      lvl <= 1'b0;
    else
      lvl <= next_lvl;
  end
endmodule

// File: rtl/sysref_edge_flag.sv
module sysref_edge_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic clr,
  output logic flag
);
  logic prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev <= 1'b0;
      flag <= 1'b0;
    end else begin
      prev <= strobe;
      if (clr)
        flag <= 1'b0;
      else if (strobe && !prev)
        flag <= 1'b1;
    end
  end
endmodule

// File: rtl/sysref_pulse_gen.sv
module sysref_pulse_gen
  import sysref_pkg::*;
#(
  parameter int EMB_E     = 1,
  parameter int MB_CYCLES = 16,
  parameter int MAX_PROD  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_rst,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              ext_sysref_in,
  input  logic              stat_wr_en,
  input  logic [CTRL_W-1:0] stat_wr_data,
  output logic              sysref_out,
  output logic [CTRL_W-1:0] status_word
);
  localparam int DEF_PER = EMB_E * MB_CYCLES;

  sr_cfg_t cfg_next;
  sr_cfg_t cfg_q;
  logic    int_lvl;
  logic    neg_lvl;
  logic    ext_q;
  logic    use_int;
  logic    sel_lvl;
  logic    flag;

  sysref_cfg_clamp #(
    .EMB_E(EMB_E), .MB_CYCLES(MB_CYCLES), .MAX_PROD(MAX_PROD)
  ) u_clamp (
    .ctrl(ctrl_word),
    .cfg (cfg_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q.mode   <= MODE_SINGLE;
      cfg_q.period <= PER_W'(DEF_PER);
      cfg_q.duty   <= DUTY_W'(DEF_PER / 2);
    end else if (gen_rst) begin
      cfg_q <= cfg_next;
    end
  end

  sysref_cycle_counter u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (gen_rst),
    .cfg       (cfg_q),
    .manual_lvl(ctrl_word[LEVEL_BIT]),
    .lvl       (int_lvl)
  );

  always_ff @(negedge clk) begin
    if (!rst_n) neg_lvl <= 1'b0;
    else        neg_lvl <= int_lvl;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext_sysref_in;
  end

  assign use_int    = ctrl_word[SRC_BIT];
  assign sel_lvl    = use_int ? int_lvl : ext_q;
  assign sysref_out = use_int ? (ctrl_word[PHASE_BIT] ? neg_lvl : int_lvl) : ext_q;

  sysref_edge_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .strobe(sel_lvl),
    .clr   (stat_wr_en && stat_wr_data[FLAG_BIT]),
    .flag  (flag)
  );

  assign status_word = {15'd0, flag, cfg_q.duty, cfg_q.period[7:0]};
endmodule

// File: rtl/sysref_pulse_gen_chk.sv
module sysref_pulse_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        gen_rst,
  input logic [31:0] ctrl_word,
  input logic        ext_sysref_in,
  input logic        stat_wr_en,
  input logic [31:0] stat_wr_data,
  input logic        sysref_out,
  input logic [31:0] status_word
);
  // R10
  ext_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !ctrl_word[7] && !$past(ctrl_word[7])) |-> sysref_out == $past(ext_sysref_in));

  // R11
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr_en && stat_wr_data[16]) |=> !status_word[16]);

  // R11
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_word[16]) |-> !$past(stat_wr_en && stat_wr_data[16]));

  // R3
  period_grain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[3:0] == 4'd0);

  // R5
  duty_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[15:8] != 8'd0) && (status_word[7:0] == 8'd0 || status_word[15:8] < status_word[7:0]));

  // R6
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_rst && $past(!gen_rst) && $past(rst_n)) |-> $stable(status_word[15:0]));

  // R7
  hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gen_rst) && ctrl_word[7] && !ctrl_word[16]) |-> !sysref_out);
endmodule

bind sysref_pulse_gen sysref_pulse_gen_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .gen_rst      (gen_rst),
  .ctrl_word    (ctrl_word),
  .ext_sysref_in(ext_sysref_in),
  .stat_wr_en   (stat_wr_en),
  .stat_wr_data (stat_wr_data),
  .sysref_out   (sysref_out),
  .status_word  (status_word)
);

// File: tb/sysref_pulse_gen_test.sv
module sysref_pulse_gen_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gen_rst = 1'b1;
  logic [31:0] ctrl_word = 32'd0;
  logic        ext_sysref_in = 1'b0;
  logic        stat_wr_en = 1'b0;
  logic [31:0] stat_wr_data = 32'd0;
  logic        sysref_out;
  logic [31:0] status_word;
  int n_chk = 0;
  int n_err = 0;

  always #(CLK_P/2) clk = ~clk;

  sysref_pulse_gen uut (
    .clk(clk), .rst_n(rst_n), .gen_rst(gen_rst), .ctrl_word(ctrl_word),
    .ext_sysref_in(ext_sysref_in), .stat_wr_en(stat_wr_en),
    .stat_wr_data(stat_wr_data), .sysref_out(sysref_out), .status_word(status_word)
  );

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] w);
    gen_rst = 1'b1; ctrl_word = w;
    tick(); tick();
    gen_rst = 1'b0;
  endtask

  task automatic measure(output int per, output int hi);
    logic prev;
    prev = sysref_out; per = 0; hi = 0;
    for (int k = 0; k < 1000; k++) begin
      tick();
      if (sysref_out && !prev) break;
      prev = sysref_out;
    end
    per = 1; hi = 1; prev = 1'b1;
    for (int k = 0; k < 1000; k++) begin
      tick();
      if (sysref_out && !prev) break;
      per++;
      if (sysref_out) hi++;
      prev = sysref_out;
    end
  endtask

  task automatic clear_flag();
    stat_wr_en = 1'b1; stat_wr_data = 32'h0001_0000;
    tick();
    stat_wr_en = 1'b0; stat_wr_data = 32'd0;
  endtask

  task automatic t_reset();
    check("R1 out", {31'd0, sysref_out}, 32'd0);
    check("R1 status", status_word, 32'h0000_0810);
  endtask

  task automatic t_periodic();
    int per, hi;
    gen_rst = 1'b1; ctrl_word = 32'h89;
    tick(); tick();
    check("R7 held low", {31'd0, sysref_out}, 32'd0);
    gen_rst = 1'b0;
    tick();
    check("R7 first rise", {31'd0, sysref_out}, 32'd1);
    measure(per, hi);
    check("R2 period mult2", per, 32);
    check("R4 half high", hi, 16);
    check("R2 status", status_word[15:0], 16'h1020);
  endtask

  task automatic t_illegal();
    int per, hi;
    apply(32'hC5); measure(per, hi);
    check("R3 mult17 period", per, 16);
    check("R3 mult17 status", status_word[7:0], 8'h10);
    apply(32'h81); measure(per, hi);
    check("R3 mult0 period", per, 16);
  endtask

  task automatic t_max();
    int per, hi;
    apply(32'hC1); measure(per, hi);
    check("R2 period 256", per, 256);
    check("R4 high 128", hi, 128);
    check("R2 status 256", status_word[15:0], 16'h8000);
  endtask

  task automatic t_gapped();
    int per, hi;
    apply(32'h0582); measure(per, hi);
    check("R5 duty5 period", per, 16);
    check("R5 duty5 high", hi, 5);
    check("R5 duty5 status", status_word[15:8], 8'h05);
    apply(32'h0F82); measure(per, hi);
    check("R5 duty15 high", hi, 15);
    apply(32'h0082); measure(per, hi);
    check("R5 duty0 high", hi, 8);
    apply(32'h1082); measure(per, hi);
    check("R5 duty16 high", hi, 8);
    check("R5 duty16 status", status_word[15:8], 8'h08);
  endtask

  task automatic t_frozen();
    int per, hi;
    apply(32'h85);
    tick(); tick();
    ctrl_word = 32'h0591;
    measure(per, hi);
    check("R6 period kept", per, 16);
    check("R6 high kept", hi, 8);
    check("R6 status kept", status_word[15:0], 16'h0810);
  endtask

  task automatic t_phase();
    apply(32'h0001_0085);
    @(posedge sysref_out);
    check("R8 falling launch", {31'd0, clk}, 32'd0);
    tick();
    apply(32'h85);
    @(posedge sysref_out);
    check("R8 rising launch", {31'd0, clk}, 32'd1);
    tick();
  endtask

  task automatic t_single();
    apply(32'h80);
    tick(); tick();
    check("R9 idle low", {31'd0, sysref_out}, 32'd0);
    clear_flag();
    ctrl_word = 32'h0002_0080;
    tick();
    check("R9 follows high", {31'd0, sysref_out}, 32'd1);
    ctrl_word = 32'h80;
    tick();
    check("R9 follows low", {31'd0, sysref_out}, 32'd0);
    check("R11 flag set", {31'd0, status_word[16]}, 32'd1);
    clear_flag();
    check("R11 flag cleared", {31'd0, status_word[16]}, 32'd0);
    ctrl_word = 32'h0002_0080;
    tick();
    stat_wr_en = 1'b1; stat_wr_data = 32'h0001_0000;
    tick();
    stat_wr_en = 1'b0; stat_wr_data = 32'd0;
    check("R11 clear wins", {31'd0, status_word[16]}, 32'd0);
    tick();
    check("R11 no late set", {31'd0, status_word[16]}, 32'd0);
    ctrl_word = 32'h80;
    tick();
  endtask

  task automatic t_external();
    ctrl_word = 32'h0001_0005;
    tick(); clear_flag();
    ext_sysref_in = 1'b1;
    tick();
    check("R10 ext high", {31'd0, sysref_out}, 32'd1);
    ext_sysref_in = 1'b0;
    tick();
    check("R10 ext low", {31'd0, sysref_out}, 32'd0);
    check("R11 ext edge flag", {31'd0, status_word[16]}, 32'd1);
    tick();
    check("R10 mode ignored", {31'd0, sysref_out}, 32'd0);
  endtask

  task automatic t_reserved();
    int highs = 0;
    apply(32'h83);
    for (int k = 0; k < 40; k++) begin
      tick();
      if (sysref_out) highs++;
    end
    check("R12 reserved low", highs, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    tick(); tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_periodic();
    t_illegal();
    t_max();
    t_gapped();
    t_frozen();
    t_phase();
    t_single();
    t_external();
    t_reserved();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule